// File: doc/BRIEF.md
# Wakeup Reason Capture Recorder

This block keeps a small sticky record of what brought the device back out of a low-power state. It watches a one-cycle strobe that marks the start of a valid low-power entry. From that strobe onward it is armed, and it ORs the following into an eight-bit record:

- every peripheral wake request whose enable mask bit is set;
- a flag for an entry that was cancelled because an interrupt pulled the core out of its wait-for-interrupt state (fall-through);
- a flag for an entry that was cancelled because a flash, lifecycle or OTP transaction was still running (abort).

Bits accumulate, so more than one reason can be seen at once. Software clears bits with write-1-to-clear accesses.

A separate capture-disable bit lets software stop recording. While it is 1, nothing is recorded and the armed state is dropped. Writing it back to 0 hands control back to hardware, and recording starts again at the next entry strobe. The record, the disable bit and the armed state are brought out as ports for the surrounding register interface to read.

Top module: `wkr_capture`

## Requirements
- R1: After a synchronous reset the record (`reason_o`), `cap_dis_o` and `armed_o` are all 0.
- R2: Before the first entry strobe after reset, no record bit is set, whatever the request, fall-through and abort inputs do.
- R3: An entry strobe (`entry_start_i`), while the disable bit is 0 and not being written to 1, sets `armed_o` from the next cycle. Capture is already active in the strobe's own cycle.
- R4: While capture is active, record bit i (i = 0..5) is set one cycle after a cycle where `wake_req_i[i]` and `wake_en_i[i]` are both 1. A request whose mask bit is 0 sets nothing.
- R5: While capture is active, `fall_thru_i` sets record bit 6 and `abort_i` sets record bit 7, one cycle later.
- R6: Record bits are only ever ORed in. Once set, a bit stays 1 through later cycles and later entries until cleared. Arming lasts until capture is disabled.
- R7: A cycle with `clr_wr_i` = 1 clears, from the next cycle, every record bit whose `clr_mask_i` bit is 1. All other bits are left unchanged.
- R8: If a clear and a hardware set hit the same bit in the same cycle, the bit is 1 afterwards.
- R9: A cycle with `cap_dis_wr_i` = 1 loads `cap_dis_i` into `cap_dis_o` for the next cycle. The write cycle itself still captures under the old value.
- R10: While `cap_dis_o` is 1 no record bit is set and `armed_o` goes to 0. After writing 0, nothing is recorded until a new entry strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| entry_start_i | input | 1 | Strobe: a valid low-power entry begins |
| fall_thru_i | input | 1 | Strobe: entry cancelled by an interrupt leaving the wait state |
| abort_i | input | 1 | Strobe: entry cancelled by an ongoing non-volatile or lifecycle transaction |
| wake_req_i | input | 6 | Raw peripheral wake requests |
| wake_en_i | input | 6 | Wake request enable mask |
| cap_dis_wr_i | input | 1 | Write strobe for the capture-disable bit |
| cap_dis_i | input | 1 | Value written to the capture-disable bit |
| clr_wr_i | input | 1 | Write-1-to-clear strobe for the record |
| clr_mask_i | input | 8 | Bits to clear (1 = clear) |
| reason_o | output | 8 | Record: bits 5:0 peripheral, bit 6 fall-through, bit 7 abort |
| cap_dis_o | output | 1 | Current capture-disable bit |
| armed_o | output | 1 | Capture armed by an entry strobe |

## Verification
Every result of this block is due exactly one clock edge after the input cycle that causes it:
- a record bit set or cleared;
- the disable bit loaded;
- the armed flag raised or dropped.

The block has no deeper pipeline. The bench drives inputs on the falling edge. A behavioural model updates on each rising edge from the same inputs, and all three outputs are compared a quarter period later, so every comparison lands in the cycle the result is due. Directed checks read the outputs at the falling edge after the stimulus cycle, which is that same single-edge latency.

// File: rtl/wkr_pkg.sv
package wkr_pkg;

    // Number of peripheral wake sources recorded
    localparam int unsigned WAKE_CNT = 6;

    // Record layout: peripheral reasons low, then the two cancellation flags.
    // The register interface decodes these positions.
    localparam int unsigned FT_POS  = WAKE_CNT;
    localparam int unsigned AB_POS  = WAKE_CNT + 1;
    localparam int unsigned REC_W   = WAKE_CNT + 2;

    typedef enum logic {
        ARM_IDLE  = 1'b0,
        ARM_ARMED = 1'b1
    } arm_state_e;

    // Hardware set request for one cycle
    typedef struct packed {
        logic                abort;
        logic                fall_thru;
        logic [WAKE_CNT-1:0] periph;
    } reason_set_t;

    function automatic logic [REC_W-1:0] set_to_vec(input reason_set_t s);
        return {s.abort, s.fall_thru, s.periph};
    endfunction

endpackage

// File: rtl/wkr_arm_ctrl.sv
module wkr_arm_ctrl
    import wkr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic entry_start_i,
    input  logic dis_wr_i,
    input  logic dis_data_i,
    output logic dis_o,
    output logic armed_o,
    output logic cap_en_o
);

    arm_state_e state_q, state_d;
    logic       dis_q, dis_d;

    always_comb begin
        dis_d = dis_wr_i ? dis_data_i : dis_q;
        if (dis_d)
            state_d = ARM_IDLE;
        else if (entry_start_i)
            state_d = ARM_ARMED;
        else
            state_d = state_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ARM_IDLE;
            dis_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            dis_q   <= dis_d;
        end
    end

    // Capture window: armed or arming this cycle, and not disabled
    assign cap_en_o = ((state_q == ARM_ARMED) || entry_start_i) && !dis_q;
    assign armed_o  = (state_q == ARM_ARMED);
    assign dis_o    = dis_q;

    assert_arm_on_entry_R3: assert property (@(posedge clk) disable iff (rst)
        (entry_start_i && !dis_q && !dis_wr_i) |=> armed_o);

    assert_dis_load_R9: assert property (@(posedge clk) disable iff (rst)
        dis_wr_i |=> (dis_o == $past(dis_data_i)));

    assert_dis_drops_arm_R10: assert property (@(posedge clk) disable iff (rst)
        (dis_q && !dis_wr_i) |=> !armed_o);

    assert_arm_holds_R6: assert property (@(posedge clk) disable iff (rst)
        (armed_o && !dis_wr_i && !dis_q) |=> armed_o);

endmodule

// File: rtl/wkr_wake_mask.sv
module wkr_wake_mask #(
    parameter int unsigned N = 6
) (
    input  logic [N-1:0] req_i,
    input  logic [N-1:0] en_i,
    input  logic         cap_en_i,
    output logic [N-1:0] hit_o
);

    for (genvar g = 0; g < N; g++) begin : g_src
        assign hit_o[g] = cap_en_i & req_i[g] & en_i[g];
    end

endmodule

// File: rtl/wkr_reason_reg.sv
module wkr_reason_reg #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_i,
    input  logic         clr_wr_i,
    input  logic [W-1:0] clr_mask_i,
    output logic [W-1:0] rec_o
);

    logic [W-1:0] rec_q;

    for (genvar b = 0; b < W; b++) begin : g_bit
        logic clr_b;
        assign clr_b = clr_wr_i & clr_mask_i[b];

        always_ff @(posedge clk) begin
            if (rst)
                rec_q[b] <= 1'b0;
            else if (set_i[b])
                rec_q[b] <= 1'b1;   // hardware set has priority
            else if (clr_b)
                rec_q[b] <= 1'b0;
        end

        assert_set_wins_R8: assert property (@(posedge clk) disable iff (rst)
            set_i[b] |=> rec_q[b]);

        assert_w1c_R7: assert property (@(posedge clk) disable iff (rst)
            (clr_b && !set_i[b]) |=> !rec_q[b]);

        assert_sticky_R6: assert property (@(posedge clk) disable iff (rst)
            (rec_q[b] && !clr_b) |=> rec_q[b]);
    end

    assign rec_o = rec_q;

endmodule

// File: rtl/wkr_capture.sv
module wkr_capture
    import wkr_pkg::*;
#(
    parameter int unsigned NUM_WAKE = WAKE_CNT,
    localparam int unsigned RW      = NUM_WAKE + 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                entry_start_i,
    input  logic                fall_thru_i,
    input  logic                abort_i,
    input  logic [NUM_WAKE-1:0] wake_req_i,
    input  logic [NUM_WAKE-1:0] wake_en_i,
    input  logic                cap_dis_wr_i,
    input  logic                cap_dis_i,
    input  logic                clr_wr_i,
    input  logic [RW-1:0]       clr_mask_i,
    output logic [RW-1:0]       reason_o,
    output logic                cap_dis_o,
    output logic                armed_o
);

    logic                cap_en;
    logic [NUM_WAKE-1:0] periph_hit;
    logic [RW-1:0]       set_vec;

    wkr_arm_ctrl u_arm (
        .clk          (clk),
        .rst          (rst),
        .entry_start_i(entry_start_i),
        .dis_wr_i     (cap_dis_wr_i),
        .dis_data_i   (cap_dis_i),
        .dis_o        (cap_dis_o),
        .armed_o      (armed_o),
        .cap_en_o     (cap_en)
    );

    wkr_wake_mask #(.N(NUM_WAKE)) u_mask (
        .req_i   (wake_req_i),
        .en_i    (wake_en_i),
        .cap_en_i(cap_en),
        .hit_o   (periph_hit)
    );

    // The packed struct form is used when the width matches the package layout
    if (NUM_WAKE == WAKE_CNT) begin : g_pkg_layout
        reason_set_t s;
        assign s.periph    = periph_hit;
        assign s.fall_thru = cap_en & fall_thru_i;
        assign s.abort     = cap_en & abort_i;
        assign set_vec     = set_to_vec(s);
    end else begin : g_generic_layout
        assign set_vec = {cap_en & abort_i, cap_en & fall_thru_i, periph_hit};
    end

    wkr_reason_reg #(.W(RW)) u_rec (
        .clk       (clk),
        .rst       (rst),
        .set_i     (set_vec),
        .clr_wr_i  (clr_wr_i),
        .clr_mask_i(clr_mask_i),
        .rec_o     (reason_o)
    );

    // No new bit may appear unless capture was armed (or arming) and enabled
    assert_no_set_unarmed_R2: assert property (@(posedge clk) disable iff (rst)
        ((!armed_o && !entry_start_i) || cap_dis_o)
            |=> ((reason_o & ~$past(reason_o)) == '0));

    assert_masked_ignored_R4: assert property (@(posedge clk) disable iff (rst)
        (!reason_o[0] && !wake_en_i[0]) |=> !reason_o[0]);

    assert_fall_thru_R5: assert property (@(posedge clk) disable iff (rst)
        (fall_thru_i && armed_o && !cap_dis_o) |=> reason_o[NUM_WAKE]);

    assert_abort_R5: assert property (@(posedge clk) disable iff (rst)
        (abort_i && armed_o && !cap_dis_o) |=> reason_o[NUM_WAKE+1]);

endmodule

// File: tb/wkr_capture_tb.sv
module wkr_capture_tb_top;

    localparam int NW = 6;
    localparam int RW = NW + 2;

    logic          clk = 1'b0;
    logic          rst;
    logic          entry_start, fall_thru, abort_s;
    logic [NW-1:0] wake_req, wake_en;
    logic          dis_wr, dis_data, clr_wr;
    logic [RW-1:0] clr_mask;
    logic [RW-1:0] reason;
    logic          cap_dis, armed;

    int    n_checks = 0;
    int    n_fail   = 0;
    string phase    = "R1";

    // reference model state
    logic [RW-1:0] m_rec;
    logic          m_dis, m_armed;

    always #10 clk = ~clk;

    wkr_capture dut_i (
        .clk          (clk),
        .rst          (rst),
        .entry_start_i(entry_start),
        .fall_thru_i  (fall_thru),
        .abort_i      (abort_s),
        .wake_req_i   (wake_req),
        .wake_en_i    (wake_en),
        .cap_dis_wr_i (dis_wr),
        .cap_dis_i    (dis_data),
        .clr_wr_i     (clr_wr),
        .clr_mask_i   (clr_mask),
        .reason_o     (reason),
        .cap_dis_o    (cap_dis),
        .armed_o      (armed)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // behavioural model, compared a quarter period after each rising edge
    always @(posedge clk) begin
        bit capturing, next_dis;
        logic [RW-1:0] add;
        if (rst) begin
            m_rec = '0; m_dis = 1'b0; m_armed = 1'b0;
        end else begin
            capturing = (m_armed || entry_start) && !m_dis;
            add = '0;
            if (capturing) begin
                for (int i = 0; i < NW; i++)
                    if (wake_req[i] && wake_en[i]) add[i] = 1'b1;
                add[NW]   = fall_thru;
                add[NW+1] = abort_s;
            end
            for (int i = 0; i < RW; i++)
                if (clr_wr && clr_mask[i]) m_rec[i] = 1'b0;
            m_rec    = m_rec | add;
            next_dis = dis_wr ? dis_data : m_dis;
            m_armed  = next_dis ? 1'b0 : (m_armed || entry_start);
            m_dis    = next_dis;
        end
        #5;
        chk(phase, "model reason", int'(reason), int'(m_rec));
        chk(phase, "model cap_dis", int'(cap_dis), int'(m_dis));
        chk(phase, "model armed", int'(armed), int'(m_armed));
    end

    task automatic idle_inputs();
        entry_start = 0; fall_thru = 0; abort_s = 0; wake_req = '0;
        dis_wr = 0; dis_data = 0; clr_wr = 0; clr_mask = '0;
    endtask

    // one stimulus cycle: inputs applied now, outputs due after the next rising edge
    task automatic cyc();
        @(negedge clk);
        idle_inputs();
    endtask

    int cycles = 0;
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=<100000", cycles);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        wake_en = '0;
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        phase = "R1";
        chk("R1", "reset reason", int'(reason), 0);
        chk("R1", "reset cap_dis", int'(cap_dis), 0);
        chk("R1", "reset armed", int'(armed), 0);

        // R2: activity before any entry strobe is not recorded
        phase = "R2";
        wake_en = '1;
        for (int k = 0; k < 4; k++) begin
            wake_req = '1; fall_thru = 1; abort_s = 1;
            cyc();
        end
        chk("R2", "reason before entry", int'(reason), 0);

        // R3: entry strobe arms, capture active in its own cycle
        phase = "R3";
        entry_start = 1; wake_req = 6'b000001;
        cyc();
        chk("R3", "armed after entry", int'(armed), 1);
        chk("R3", "bit0 in strobe cycle", int'(reason), 8'h01);

        // R4: mask filters requests
        phase = "R4";
        wake_en = 6'b001111; wake_req = 6'b111100;
        cyc();
        chk("R4", "masked requests", int'(reason), 8'h0D);

        // R5: fall-through and abort flags
        phase = "R5";
        fall_thru = 1;
        cyc();
        chk("R5", "fall-through bit6", int'(reason), 8'h4D);
        abort_s = 1;
        cyc();
        chk("R5", "abort bit7", int'(reason), 8'hCD);

        // R6: sticky across idle cycles and a second entry
        phase = "R6";
        repeat (5) cyc();
        entry_start = 1; wake_en = '1; wake_req = 6'b100000;
        cyc();
        chk("R6", "accumulated", int'(reason), 8'hED);
        chk("R6", "still armed", int'(armed), 1);

        // R7: write-1-to-clear
        phase = "R7";
        clr_wr = 1; clr_mask = 8'h41;
        cyc();
        chk("R7", "partial clear", int'(reason), 8'hAC);

        // R8: set beats clear on same bit
        phase = "R8";
        clr_wr = 1; clr_mask = 8'h84; abort_s = 1;
        cyc();
        chk("R8", "set wins", int'(reason), 8'hA8);

        // R9: disable write captures in its own cycle, loads next
        phase = "R9";
        clr_wr = 1; clr_mask = '1;
        cyc();
        chk("R9", "cleared all", int'(reason), 0);
        dis_wr = 1; dis_data = 1; wake_req = 6'b000010;
        cyc();
        chk("R9", "cap_dis loaded", int'(cap_dis), 1);
        chk("R9", "write cycle captured", int'(reason), 8'h02);

        // R10: nothing recorded while disabled, arming dropped
        phase = "R10";
        chk("R10", "disarmed", int'(armed), 0);
        for (int k = 0; k < 3; k++) begin
            entry_start = (k == 1); wake_req = '1; fall_thru = 1; abort_s = 1;
            cyc();
        end
        chk("R10", "no capture disabled", int'(reason), 8'h02);
        dis_wr = 1; dis_data = 0;
        cyc();
        chk("R9", "cap_dis cleared", int'(cap_dis), 0);
        wake_req = 6'b010000; fall_thru = 1;
        cyc();
        chk("R10", "no capture before new entry", int'(reason), 8'h02);
        entry_start = 1; wake_req = 6'b010000;
        cyc();
        chk("R10", "capture after new entry", int'(reason), 8'h12);
        chk("R3", "rearmed", int'(armed), 1);

        // mixed pattern stream checked by the model
        phase = "R6";
        for (int k = 0; k < 40; k++) begin
            wake_req    = 6'(k * 7 + 3);
            wake_en     = 6'(k * 5 + 1);
            fall_thru   = (k % 9 == 4);
            abort_s     = (k % 11 == 6);
            entry_start = (k % 13 == 0);
            clr_wr      = (k % 4 == 3);
            clr_mask    = 8'(k * 37);
            dis_wr      = (k % 10 == 7);
            dis_data    = (k % 20 == 7);
            cyc();
        end

        repeat (2) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule